// File: doc/BRIEF.md
# Tagged Next-Line Prefetch Engine

This block watches the demand accesses that a cache's tag array resolves and issues prefetch requests for the next sequential line. It keeps the cache's extra per-line flag correct: the flag marks a line that a prefetch brought in and that no access has referenced yet. A demand miss on line L makes line L+1 a candidate. The first hit on a flagged line also makes L+1 a candidate and clears that line's flag. Because of this, a sequential stream that keeps hitting on prefetched lines keeps the engine one line ahead, instead of stalling at every other line.

A candidate is dropped in four cases: the cache reports that L+1 is already present, the line is already waiting in the request queue, the queue is full, or L is the last line of the address space. Accepted candidates wait in a small FIFO until the memory side takes them with a valid/ready handshake. Flag writes go back to the tag array on two registered lanes. One lane clears the flag on a first use. The other writes the flag of each installed line: 1 for a prefetch fill, 0 for a demand fill.

Top module: `tobl_prefetcher`

## Requirements
- R1: After reset, `pf_valid`, `upd_clr_valid` and `upd_wr_valid` are 0.
- R2: An access with `acc_hit`=0 to line L (L not all ones), while `nxt_present`=0, L+1 is not queued and the queue is not full, puts L+1 in the queue. If the queue was empty, `pf_valid`=1 and `pf_line`=L+1 after the next clock edge.
- R3: An access with `acc_hit`=1 and `acc_tag`=1 to line L makes L+1 a candidate under the same conditions as R2. One cycle later it drives `upd_clr_valid`=1 with `upd_clr_line`=L.
- R4: An access with `acc_hit`=1 and `acc_tag`=0 queues nothing and drives no flag write.
- R5: `nxt_line` equals `acc_line`+1. A candidate is dropped when `nxt_present`=1 in the same cycle.
- R6: A candidate is dropped when an equal line address is already held in the queue.
- R7: The queue holds DEPTH (4) entries and hands them out in arrival order. A candidate that arrives while the queue holds DEPTH entries is dropped, even if an entry leaves in the same cycle.
- R8: `fill_valid`=1 drives `upd_wr_valid`=1, `upd_wr_line`=`fill_line` and `upd_wr_bit`=`fill_is_pf` one cycle later. The bit is 1 for a prefetch fill and 0 for a demand fill.
- R9: An access to the all-ones line address never queues a prefetch.
- R10: A flag clear and a fill write in the same cycle both appear on their own lanes in the following cycle.
- R11: An entry leaves the queue in each cycle where `pf_valid` and `pf_ready` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | A demand access is resolved this cycle |
| acc_line | input | LINE_W | Line address of the access |
| acc_hit | input | 1 | Access hit in the cache |
| acc_tag | input | 1 | Prefetched-unused flag of the hit line |
| nxt_line | output | LINE_W | Line address (acc_line+1) for the cache presence probe |
| nxt_present | input | 1 | Probed line is present in the cache |
| fill_valid | input | 1 | A line is being installed |
| fill_line | input | LINE_W | Line address being installed |
| fill_is_pf | input | 1 | Installed line came from a prefetch |
| upd_clr_valid | output | 1 | Clear the flag of upd_clr_line |
| upd_clr_line | output | LINE_W | Line whose flag is cleared |
| upd_wr_valid | output | 1 | Write the flag of upd_wr_line |
| upd_wr_line | output | LINE_W | Line whose flag is written |
| upd_wr_bit | output | 1 | Flag value to write |
| pf_valid | output | 1 | A prefetch request is offered |
| pf_line | output | LINE_W | Line address to prefetch |
| pf_ready | input | 1 | Memory side takes the request |

## Verification
A wrong queue pointer or occupancy bit shows up at the ports at once. The next pop returns the wrong line or the lines out of order, or `pf_valid` stays high after the queue has drained. A broken duplicate compare shows as the same line offered twice in a row. A trigger that decodes the flag wrongly shows one cycle after the access: the clear lane fires on a hit to a clean line, or it stays silent on a hit to a flagged line. A wrong full limit shows only once the queue has filled, as an extra entry or a missing entry when the queue is drained.

// File: rtl/tobl_pkg.sv
package tobl_pkg;

    typedef enum logic [1:0] {
        TRG_NONE      = 2'd0,
        TRG_MISS      = 2'd1,
        TRG_FIRST_USE = 2'd2
    } trig_kind_e;

    function automatic trig_kind_e classify(input logic v, input logic hit, input logic tag);
        if (!v)
            return TRG_NONE;
        else if (!hit)
            return TRG_MISS;
        else if (tag)
            return TRG_FIRST_USE;
        else
            return TRG_NONE;
    endfunction

endpackage

// File: rtl/tobl_trigger.sv
module tobl_trigger
    import tobl_pkg::*;
#(
    parameter int LINE_W = 26
) (
    input  logic              acc_valid,
    input  logic [LINE_W-1:0] acc_line,
    input  logic              acc_hit,
    input  logic              acc_tag,
    output trig_kind_e        kind,
    output logic              cand_req,
    output logic [LINE_W-1:0] cand_line,
    output logic              clr_req
);
    localparam logic [LINE_W-1:0] TOP_LINE = '1;

    logic at_top;

    always_comb begin
        kind      = classify(acc_valid, acc_hit, acc_tag);
        at_top    = (acc_line == TOP_LINE);
        cand_line = acc_line + LINE_W'(1);
        cand_req  = (kind != TRG_NONE) && !at_top;
        clr_req   = (kind == TRG_FIRST_USE);
    end

endmodule

// File: rtl/tobl_queue.sv
module tobl_queue #(
    parameter int LINE_W = 26,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cand_req,
    input  logic [LINE_W-1:0] cand_line,
    input  logic              cand_present,
    output logic              cand_taken,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line,
    input  logic              pf_ready
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [PW-1:0] LAST = PW'(DEPTH - 1);

    logic [LINE_W-1:0] mem [DEPTH];
    logic [DEPTH-1:0]  occ;
    logic [DEPTH-1:0]  match;
    logic [PW-1:0]     head, tail;
    logic [CW-1:0]     count;
    logic              full, pop, push;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign match[i] = occ[i] && (mem[i] == cand_line);
    end

    always_comb begin
        full       = (count == CW'(DEPTH));
        push       = cand_req && !cand_present && !(|match) && !full;
        cand_taken = push;
        pf_valid   = occ[head];
        pf_line    = mem[head];
        pop        = pf_valid && pf_ready;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            occ   <= '0;
            head  <= '0;
            tail  <= '0;
            count <= '0;
        end else begin
            if (push) begin
                mem[tail] <= cand_line;
                tail      <= (tail == LAST) ? '0 : tail + PW'(1);
            end
            if (pop)
                head <= (head == LAST) ? '0 : head + PW'(1);
            for (int i = 0; i < DEPTH; i++) begin
                if (push && tail == PW'(i))
                    occ[i] <= 1'b1;
                else if (pop && head == PW'(i))
                    occ[i] <= 1'b0;
            end
            if (push && !pop)
                count <= count + CW'(1);
            else if (pop && !push)
                count <= count - CW'(1);
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) count <= CW'(DEPTH)); // R7
    AST_OCC_MATCHES_COUNT: assert property (@(posedge clk) disable iff (rst) $countones(occ) == int'(count)); // R7
    AST_NO_PUSH_WHEN_FULL: assert property (@(posedge clk) disable iff (rst) full |-> !push); // R7
    AST_POP_ADVANCES: assert property (@(posedge clk) disable iff (rst) (pop && !push) |=> count == $past(count) - CW'(1)); // R11

endmodule

// File: rtl/tobl_tagupd.sv
module tobl_tagupd #(
    parameter int LINE_W = 26
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr_req,
    input  logic [LINE_W-1:0] clr_line,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              fill_is_pf,
    output logic              upd_clr_valid,
    output logic [LINE_W-1:0] upd_clr_line,
    output logic              upd_wr_valid,
    output logic [LINE_W-1:0] upd_wr_line,
    output logic              upd_wr_bit
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upd_clr_valid <= 1'b0;
            upd_clr_line  <= '0;
            upd_wr_valid  <= 1'b0;
            upd_wr_line   <= '0;
            upd_wr_bit    <= 1'b0;
        end else begin
            upd_clr_valid <= clr_req;
            upd_clr_line  <= clr_line;
            upd_wr_valid  <= fill_valid;
            upd_wr_line   <= fill_line;
            upd_wr_bit    <= fill_is_pf;
        end
    end

    AST_FILL_WRITE: assert property (@(posedge clk) disable iff (rst) fill_valid |=> upd_wr_valid && upd_wr_bit == $past(fill_is_pf) && upd_wr_line == $past(fill_line)); // R8
    AST_CLR_WRITE: assert property (@(posedge clk) disable iff (rst) clr_req |=> upd_clr_valid && upd_clr_line == $past(clr_line)); // R3

endmodule

// File: rtl/tobl_prefetcher.sv
module tobl_prefetcher
    import tobl_pkg::*;
#(
    parameter int LINE_W = 26,
    parameter int DEPTH  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              acc_valid,
    input  logic [LINE_W-1:0] acc_line,
    input  logic              acc_hit,
    input  logic              acc_tag,
    output logic [LINE_W-1:0] nxt_line,
    input  logic              nxt_present,
    input  logic              fill_valid,
    input  logic [LINE_W-1:0] fill_line,
    input  logic              fill_is_pf,
    output logic              upd_clr_valid,
    output logic [LINE_W-1:0] upd_clr_line,
    output logic              upd_wr_valid,
    output logic [LINE_W-1:0] upd_wr_line,
    output logic              upd_wr_bit,
    output logic              pf_valid,
    output logic [LINE_W-1:0] pf_line,
    input  logic              pf_ready
);
    trig_kind_e        kind;
    logic              cand_req, clr_req, cand_taken;
    logic [LINE_W-1:0] cand_line;

    tobl_trigger #(.LINE_W(LINE_W)) u_trig (
        .acc_valid (acc_valid),
        .acc_line  (acc_line),
        .acc_hit   (acc_hit),
        .acc_tag   (acc_tag),
        .kind      (kind),
        .cand_req  (cand_req),
        .cand_line (cand_line),
        .clr_req   (clr_req)
    );

    assign nxt_line = cand_line;

    tobl_queue #(.LINE_W(LINE_W), .DEPTH(DEPTH)) u_queue (
        .clk          (clk),
        .rst          (rst),
        .cand_req     (cand_req),
        .cand_line    (cand_line),
        .cand_present (nxt_present),
        .cand_taken   (cand_taken),
        .pf_valid     (pf_valid),
        .pf_line      (pf_line),
        .pf_ready     (pf_ready)
    );

    tobl_tagupd #(.LINE_W(LINE_W)) u_tagupd (
        .clk           (clk),
        .rst           (rst),
        .clr_req       (clr_req),
        .clr_line      (acc_line),
        .fill_valid    (fill_valid),
        .fill_line     (fill_line),
        .fill_is_pf    (fill_is_pf),
        .upd_clr_valid (upd_clr_valid),
        .upd_clr_line  (upd_clr_line),
        .upd_wr_valid  (upd_wr_valid),
        .upd_wr_line   (upd_wr_line),
        .upd_wr_bit    (upd_wr_bit)
    );

    AST_CLEAN_HIT_QUIET: assert property (@(posedge clk) disable iff (rst) (acc_valid && acc_hit && !acc_tag) |-> !cand_taken); // R4
    AST_PRESENT_BLOCKS: assert property (@(posedge clk) disable iff (rst) nxt_present |-> !cand_taken); // R5
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst) (acc_line == '1) |-> !cand_taken); // R9
    AST_CLEAN_HIT_NO_CLR: assert property (@(posedge clk) disable iff (rst) (acc_valid && acc_hit && !acc_tag) |=> !upd_clr_valid); // R4
    AST_QUIET_RESET: assert property (@(posedge clk) $past(rst) |-> !pf_valid && !upd_clr_valid && !upd_wr_valid); // R1

endmodule

// File: tb/test_tobl_prefetcher.sv
module test_tobl_prefetcher;
    localparam int LW = 6;
    localparam int TOP = (1 << LW) - 1;

    logic clk = 0, rst = 1;
    logic acc_valid = 0, acc_hit = 0, acc_tag = 0, nxt_present = 0;
    logic [LW-1:0] acc_line = '0, fill_line = '0;
    logic fill_valid = 0, fill_is_pf = 0, pf_ready = 0;
    logic [LW-1:0] nxt_line, upd_clr_line, upd_wr_line, pf_line;
    logic upd_clr_valid, upd_wr_valid, upd_wr_bit, pf_valid;
    int total = 0, bad = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tobl_prefetcher #(.LINE_W(LW), .DEPTH(4)) i_tobl_prefetcher (
        .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_line(acc_line),
        .acc_hit(acc_hit), .acc_tag(acc_tag), .nxt_line(nxt_line),
        .nxt_present(nxt_present), .fill_valid(fill_valid), .fill_line(fill_line),
        .fill_is_pf(fill_is_pf), .upd_clr_valid(upd_clr_valid),
        .upd_clr_line(upd_clr_line), .upd_wr_valid(upd_wr_valid),
        .upd_wr_line(upd_wr_line), .upd_wr_bit(upd_wr_bit),
        .pf_valid(pf_valid), .pf_line(pf_line), .pf_ready(pf_ready));

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // drive one access on a negedge, return on the next negedge (registered results visible)
    task automatic access(input int line, input bit hit, input bit tag, input bit present);
        @(negedge clk);
        acc_valid = 1; acc_line = LW'(line); acc_hit = hit; acc_tag = tag; nxt_present = present;
        #1;
        if (line != TOP) chk("R5 nxt_line", int'(nxt_line), line + 1);
        @(negedge clk);
        acc_valid = 0; acc_hit = 0; acc_tag = 0; nxt_present = 0;
    endtask

    task automatic pop_expect(input string req, input int exp_line);
        @(negedge clk);
        chk({req, " valid"}, int'(pf_valid), 1);
        chk({req, " line"}, int'(pf_line), exp_line);
        pf_ready = 1;
        @(negedge clk);
        pf_ready = 0;
    endtask

    task automatic expect_empty(input string req);
        @(negedge clk);
        chk({req, " empty"}, int'(pf_valid), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        #1;
        chk("R1 pf_valid", int'(pf_valid), 0);
        chk("R1 clr", int'(upd_clr_valid), 0);
        chk("R1 wr", int'(upd_wr_valid), 0);

        // R2 / R9: sweep every line with a demand miss
        for (int l = 0; l <= TOP; l++) begin
            access(l, 0, 0, 0);
            if (l == TOP) begin
                chk("R9 top line", int'(pf_valid), 0);
            end else begin
                chk("R2 miss valid", int'(pf_valid), 1);
                chk("R2 miss line", int'(pf_line), l + 1);
                pf_ready = 1;
                @(negedge clk);
                pf_ready = 0;
            end
        end

        // R3 / R4 / R5 sweep: hit/tag/present combinations over a set of lines
        for (int l = 0; l < TOP; l += 7) begin
            for (int m = 0; m < 8; m++) begin
                bit h = m[0], t = m[1], p = m[2];
                bit exp_pf = (!h || t) && !p;
                bit exp_clr = h && t;
                access(l, h, t, p);
                chk("R3 R4 clear lane", int'(upd_clr_valid), int'(exp_clr));
                if (exp_clr) chk("R3 clear line", int'(upd_clr_line), l);
                chk("R4 R5 queued", int'(pf_valid), int'(exp_pf));
                if (exp_pf) begin
                    chk("R3 line", int'(pf_line), l + 1);
                    pf_ready = 1;
                    @(negedge clk);
                    pf_ready = 0;
                end
            end
        end

        // R6: duplicate suppressed
        access(5, 0, 0, 0);
        access(5, 1, 1, 0);
        pop_expect("R6 first", 6);
        expect_empty("R6 no duplicate");

        // R7: order and drop when full
        access(10, 0, 0, 0);
        access(20, 0, 0, 0);
        access(30, 0, 0, 0);
        access(40, 0, 0, 0);
        access(50, 0, 0, 0);
        pop_expect("R7 order", 11);
        pop_expect("R7 order", 21);
        pop_expect("R7 order", 31);
        pop_expect("R7 order", 41);
        expect_empty("R7 dropped when full");

        // R7 / R11: full with simultaneous pop still drops
        access(10, 0, 0, 0);
        access(20, 0, 0, 0);
        access(30, 0, 0, 0);
        access(40, 0, 0, 0);
        @(negedge clk);
        acc_valid = 1; acc_line = 6'd60; acc_hit = 0; pf_ready = 1;
        @(negedge clk);
        acc_valid = 0; pf_ready = 0;
        pop_expect("R11 after pop", 21);
        pop_expect("R11 after pop", 31);
        pop_expect("R7 full drop with pop", 41);
        expect_empty("R7 full drop with pop");

        // R8 / R10: fills, alone and alongside a clear
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            fill_valid = 1; fill_line = LW'(9 + k); fill_is_pf = k[0];
            @(negedge clk);
            fill_valid = 0;
            chk("R8 wr valid", int'(upd_wr_valid), 1);
            chk("R8 wr line", int'(upd_wr_line), 9 + k);
            chk("R8 wr bit", int'(upd_wr_bit), k);
        end
        @(negedge clk);
        fill_valid = 1; fill_line = 6'd33; fill_is_pf = 1;
        acc_valid = 1; acc_line = 6'd17; acc_hit = 1; acc_tag = 1; nxt_present = 1;
        @(negedge clk);
        fill_valid = 0; acc_valid = 0; acc_hit = 0; acc_tag = 0; nxt_present = 0;
        chk("R10 clr", int'(upd_clr_valid), 1);
        chk("R10 clr line", int'(upd_clr_line), 17);
        chk("R10 wr", int'(upd_wr_valid), 1);
        chk("R10 wr line", int'(upd_wr_line), 33);
        @(negedge clk);
        chk("R8 wr idle", int'(upd_wr_valid), 0);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                total++; bad++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule